// File: doc/BRIEF.md
# Address error exception frame sequencer

This block assembles the stack frame that a 16-bit-bus processor core stores when an access lands on an odd address. A single-cycle fault pulse captures four facts: the instruction register, the 32-bit faulting address, the kind of access (instruction fetch, data read or data write) and whether the core was in supervisor state. The block then pushes a fixed series of 16-bit words onto the stack through a plain request/acknowledge write port. It moves the stack pointer down by two bytes before each word.

The frame, from the first word pushed to the last, is: the instruction register, the low half of the address, the high half of the address and a status word. The status word carries the access-type flags in its low five bits. Its upper bits, which would otherwise be undefined, are filled with the matching bits of the instruction register. When the last word is acknowledged, the block raises a one-cycle completion pulse and leaves the final stack pointer on an output.

Top module: `addr_err_frame_seq`

## Requirements
- R1: After reset, busy_o, wr_req_o and done_o are 0 and sp_o is 0.
- R2: When idle, a cycle with fault_i=1 makes busy_o and wr_req_o 1 from the next cycle. The first write then targets sp_i-2 and carries fault_ir_i.
- R3: The words are written in this order: instruction register, address bits [15:0], address bits [31:16], status word. They go to sp_i-2, sp_i-4, sp_i-6 and sp_i-8, modulo 2^32.
- R4: While wr_req_o=1 and wr_ack_i=0, wr_req_o stays 1 and wr_addr_o and wr_data_o do not change. A cycle with wr_ack_i=1 moves the port to the next word in the following cycle.
- R5: Status word bits [15:5] equal instruction register bits [15:5], and bit 3 is 0.
- R6: Status word bit 2 equals fault_super_i as captured with the fault.
- R7: The access type is taken from fault_kind_i: 0 is a fetch, 1 is a data read, 2 and 3 are data writes. Bit 4 marks a read, bit 1 marks a program access and bit 0 marks a data access. Status bits {4,1,0} are therefore 3'b110 for a fetch, 3'b101 for a read and 3'b001 for a write.
- R8: In the cycle after the status word is acknowledged, done_o is 1 for exactly one cycle and busy_o and wr_req_o are 0. sp_o then shows sp_i-8 and keeps that value until the next fault.
- R9: A fault_i pulse that arrives while busy_o=1 has no effect on the frame being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_i | input | 1 | Single-cycle address error request |
| fault_ir_i | input | 16 | Instruction register at the fault |
| fault_addr_i | input | 32 | Faulting access address |
| fault_kind_i | input | 2 | Access kind: 0 fetch, 1 read, 2/3 write |
| fault_super_i | input | 1 | Supervisor state at the fault |
| sp_i | input | 32 | Stack pointer before the frame |
| wr_req_o | output | 1 | Stack write request |
| wr_addr_o | output | 32 | Stack write byte address |
| wr_data_o | output | 16 | Stack write data word |
| wr_ack_i | input | 1 | Write acknowledge |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sp_o | output | 32 | Current or final stack pointer |

## Verification
The bench sweeps every access kind (including the reserved value 3), both supervisor settings and a set of instruction register values. The IR values are all-ones, all-zeros, low-five-bits-only and mixed patterns. These separate the copied upper IR field from the flag bits and show that IR bits [4:0] never leak into the status word. The acknowledge delay is varied from zero to two cycles, which shows that each word is held until accepted and that back-to-back acknowledges still advance correctly. Stack pointers near zero check that the address decrement wraps. A second fault pulse is injected in the middle of some frames to show that a request is ignored while the block is busy.

// File: rtl/afe_pkg.sv
package afe_pkg;
    typedef enum logic [1:0] {
        AK_FETCH = 2'd0,
        AK_READ  = 2'd1,
        AK_WRITE = 2'd2,
        AK_RSVD  = 2'd3
    } acc_kind_e;

    localparam int FLAG_BITS = 5;
endpackage

// File: rtl/afe_info_compose.sv
module afe_info_compose
    import afe_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] ir_i,
    input  logic [1:0]    kind_i,
    input  logic          super_i,
    output logic [DW-1:0] info_o
);
    logic [FLAG_BITS-1:0] flags_d;

    always_comb begin
        flags_d    = '0;
        flags_d[2] = super_i;
        unique case (acc_kind_e'(kind_i))
            AK_FETCH: begin
                flags_d[4] = 1'b1;
                flags_d[1] = 1'b1;
            end
            AK_READ: begin
                flags_d[4] = 1'b1;
                flags_d[0] = 1'b1;
            end
            default: flags_d[0] = 1'b1;
        endcase
        info_o = {ir_i[DW-1:FLAG_BITS], flags_d};
    end
endmodule

// File: rtl/afe_word_pick.sv
module afe_word_pick #(
    parameter int DW     = 16,
    parameter int AW     = 32,
    parameter int NWORDS = 2 + AW / DW,
    parameter int IW     = $clog2(NWORDS)
) (
    input  logic [DW-1:0] ir_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] info_i,
    input  logic [IW-1:0] idx_i,
    output logic [DW-1:0] word_o
);
    localparam int ASLICES = AW / DW;

    logic [DW-1:0] words_d [NWORDS];

    assign words_d[0]        = ir_i;
    assign words_d[NWORDS-1] = info_i;

    // address slices go out least significant first
    for (genvar g = 0; g < ASLICES; g++) begin : g_slice
        assign words_d[g+1] = addr_i[g*DW +: DW];
    end

    always_comb begin
        word_o = '0;
        for (int k = 0; k < NWORDS; k++) begin
            if (idx_i == IW'(k)) word_o = words_d[k];
        end
    end
endmodule

// File: rtl/addr_err_frame_seq.sv
module addr_err_frame_seq #(
    parameter int DW = 16,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fault_i,
    input  logic [DW-1:0] fault_ir_i,
    input  logic [AW-1:0] fault_addr_i,
    input  logic [1:0]    fault_kind_i,
    input  logic          fault_super_i,
    input  logic [AW-1:0] sp_i,
    output logic          wr_req_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o,
    input  logic          wr_ack_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [AW-1:0] sp_o
);
    localparam int NWORDS = 2 + AW / DW;
    localparam int IW     = $clog2(NWORDS);
    localparam int STEP   = DW / 8;
    localparam logic [IW-1:0] LAST = IW'(NWORDS - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [IW-1:0] idx;
        logic [AW-1:0] sp;
        logic [DW-1:0] ir;
        logic [AW-1:0] addr;
        logic [DW-1:0] info;
    } st_t;

    st_t st_q, st_d;
    logic [DW-1:0] info_w;
    logic [DW-1:0] word_w;

    afe_info_compose #(.DW(DW)) u_info (
        .ir_i    (fault_ir_i),
        .kind_i  (fault_kind_i),
        .super_i (fault_super_i),
        .info_o  (info_w)
    );

    afe_word_pick #(.DW(DW), .AW(AW), .NWORDS(NWORDS), .IW(IW)) u_pick (
        .ir_i   (st_q.ir),
        .addr_i (st_q.addr),
        .info_i (st_q.info),
        .idx_i  (st_q.idx),
        .word_o (word_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (fault_i) begin
                st_d.busy = 1'b1;
                st_d.idx  = '0;
                st_d.sp   = sp_i - AW'(STEP);
                st_d.ir   = fault_ir_i;
                st_d.addr = fault_addr_i;
                st_d.info = info_w;
            end
        end else if (wr_ack_i) begin
            if (st_q.idx == LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
                st_d.sp  = st_q.sp - AW'(STEP);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_req_o  = st_q.busy;
    assign wr_addr_o = st_q.sp;
    assign wr_data_o = word_w;
    assign busy_o    = st_q.busy;
    assign done_o    = st_q.done;
    assign sp_o      = st_q.sp;

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o && wr_ack_i && (st_q.idx != LAST) |=> wr_addr_o == $past(wr_addr_o) - AW'(STEP));

    p_info_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o && (st_q.idx == LAST) |-> wr_data_o[DW-1:5] == st_q.ir[DW-1:5] && !wr_data_o[3]);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && !wr_req_o);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && fault_i |=> $stable(st_q.ir) && $stable(st_q.addr) && $stable(st_q.info));
endmodule

// File: tb/addr_err_frame_seq_tb.sv
module addr_err_frame_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fault_i = 1'b0;
    logic [15:0] fault_ir_i = '0;
    logic [31:0] fault_addr_i = '0;
    logic [1:0]  fault_kind_i = '0;
    logic        fault_super_i = 1'b0;
    logic [31:0] sp_i = '0;
    logic        wr_req_o;
    logic [31:0] wr_addr_o;
    logic [15:0] wr_data_o;
    logic        wr_ack_i = 1'b0;
    logic        busy_o;
    logic        done_o;
    logic [31:0] sp_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    addr_err_frame_seq u_dut (
        .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .fault_ir_i(fault_ir_i),
        .fault_addr_i(fault_addr_i), .fault_kind_i(fault_kind_i),
        .fault_super_i(fault_super_i), .sp_i(sp_i), .wr_req_o(wr_req_o),
        .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i),
        .busy_o(busy_o), .done_o(done_o), .sp_o(sp_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_info(input logic [15:0] ir, input logic [1:0] kind,
                                             input logic sup);
        logic [15:0] v;
        v = (ir & 16'hFFE0) | (sup ? 16'h0004 : 16'h0000);
        case (kind)
            2'd0:    v = v | 16'h0012;
            2'd1:    v = v | 16'h0011;
            default: v = v | 16'h0001;
        endcase
        return v;
    endfunction

    task automatic run_frame(input logic [15:0] ir, input logic [31:0] addr,
                             input logic [1:0] kind, input logic sup,
                             input logic [31:0] sp, input int dly, input bit poke);
        logic [15:0] words [4];
        words[0] = ir;
        words[1] = addr[15:0];
        words[2] = addr[31:16];
        words[3] = exp_info(ir, kind, sup);
        @(negedge clk);
        fault_i = 1'b1; fault_ir_i = ir; fault_addr_i = addr;
        fault_kind_i = kind; fault_super_i = sup; sp_i = sp;
        @(negedge clk);
        fault_i = 1'b0;
        chk("R2 busy", 32'(busy_o), 32'd1);
        chk("R2 req", 32'(wr_req_o), 32'd1);
        for (int k = 0; k < 4; k++) begin
            for (int d = 0; d < dly; d++) begin
                if (poke && k == 1 && d == 0) begin
                    fault_i = 1'b1; fault_ir_i = ~ir; fault_addr_i = ~addr;
                    fault_kind_i = kind + 2'd1; fault_super_i = ~sup; sp_i = sp + 32'h100;
                end
                chk("R4 hold req", 32'(wr_req_o), 32'd1);
                chk("R4 hold addr", wr_addr_o, sp - 32'(2 * (k + 1)));
                chk("R4 hold data", 32'(wr_data_o), 32'(words[k]));
                @(negedge clk);
                fault_i = 1'b0;
            end
            if (k == 3) begin
                chk("R5 info upper", 32'(wr_data_o[15:5]), 32'(ir[15:5]));
                chk("R6 super bit", 32'(wr_data_o[2]), 32'(sup));
                chk("R7 type bits", 32'({wr_data_o[4], wr_data_o[1], wr_data_o[0]}),
                    (kind == 2'd0) ? 32'd6 : (kind == 2'd1) ? 32'd5 : 32'd1);
            end
            chk("R3 addr", wr_addr_o, sp - 32'(2 * (k + 1)));
            chk("R3 data", 32'(wr_data_o), 32'(words[k]));
            wr_ack_i = 1'b1;
            @(negedge clk);
            wr_ack_i = 1'b0;
        end
        chk("R8 done", 32'(done_o), 32'd1);
        chk("R8 busy low", 32'(busy_o), 32'd0);
        chk("R8 req low", 32'(wr_req_o), 32'd0);
        chk("R8 final sp", sp_o, sp - 32'd8);
        @(negedge clk);
        chk("R8 done pulse", 32'(done_o), 32'd0);
        chk("R8 sp held", sp_o, sp - 32'd8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy", 32'(busy_o), 32'd0);
        chk("R1 req", 32'(wr_req_o), 32'd0);
        chk("R1 done", 32'(done_o), 32'd0);
        chk("R1 sp", sp_o, 32'd0);
        rst_n = 1'b1;
        begin
            logic [15:0] irs [5];
            irs[0] = 16'hFFFF; irs[1] = 16'h0000; irs[2] = 16'h001F;
            irs[3] = 16'hA5C3; irs[4] = 16'h4E71;
            for (int kd = 0; kd < 4; kd++)
                for (int s = 0; s < 2; s++)
                    for (int i = 0; i < 5; i++)
                        for (int dl = 0; dl < 3; dl++)
                            run_frame(irs[i], 32'h00F0_0001 + 32'(i * 4099 + kd * 77),
                                      2'(kd), s[0], 32'h0000_1000 + 32'(i * 16),
                                      dl, (dl == 2) && (i == 3));
            run_frame(16'h1234, 32'hDEAD_BEEF, 2'd1, 1'b1, 32'h0000_0004, 1, 1'b0);
            run_frame(16'h8001, 32'h0000_0003, 2'd0, 1'b0, 32'h0000_0000, 0, 1'b0);
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule